// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Core

This block is a single-cycle processor for a small 64-bit load/store instruction set: register-to-register add, subtract, AND and OR; add and subtract with an unsigned 12-bit immediate; 64-bit word load and store with a signed 9-bit offset; an unconditional PC-relative jump; and a branch taken when a register is zero. In every clock cycle it fetches one 32-bit instruction, decodes it into control signals, and reads two operands from a 32 x 64-bit register file. It then forms the immediate for the instruction's format, runs the ALU, accesses the data memory, writes back the result and selects the next PC.

Both memories are internal word arrays. They are filled through a preload write port while reset is held. After reset is released the core runs freely from address 0. The current PC, the data word returned by a load, and a flag that is raised when the PC equals a supplied end address are brought out so that a program's results can be observed.

Top module: `sc64_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 31 writable registers become 0. The core performs no register or data-memory write during reset.
- R2: An instruction whose bits 31:21 equal 10001011000 (ADD), 11001011000 (SUB), 10001010000 (AND) or 10101010000 (ORR) writes the 64-bit result of register(bits 9:5) op register(bits 20:16) into register(bits 4:0). Subtraction is modulo 2^64.
- R3: An instruction whose bits 31:22 equal 1001000100 (add) or 1101000100 (subtract) combines register(bits 9:5) with bits 21:10 zero-extended to 64 bits. The result goes to register(bits 4:0).
- R4: Bits 31:21 = 11111000010 loads, and 11111000000 stores, the data word at byte address register(bits 9:5) plus bits 20:12 sign-extended. The word index is address bits [n:3]. A load writes register(bits 4:0). A store writes register(bits 4:0) to memory and writes no register.
- R5: Register index 31 always reads as 0, and any write to it is discarded.
- R6: Bits 31:24 = 10110100 is a zero-test branch on register(bits 4:0). When that register is 0 the next PC is PC + (sign-extended bits 23:5 << 2); otherwise it is PC + 4.
- R7: Bits 31:26 = 000101 is an unconditional jump to PC + (sign-extended bits 25:0 << 2). Negative offsets jump backwards.
- R8: Unless a branch is taken, the next PC is PC + 4. Instructions are fetched from the 32-bit word at index PC bits [n:2].
- R9: An opcode that matches none of the patterns above writes no register and no memory, and the PC advances by 4.
- R10: `rdata_o` carries the addressed data word during a load cycle and is 0 in every other cycle.
- R11: `halt_o` is high exactly in the cycles where `pc_o` equals `end_addr`.
- R12: The program that masks the low nibble of 0x123456789ABCEDFA with (0xA OR 5) and counts it down to zero in a loop leaves 0xA in the data word at byte address 0x20.
- R13: A preload write (`prog_we` high) stores `prog_wdata` at word index `prog_addr`. With `prog_dsel` = 0 the write goes to instruction memory (low 32 bits); with `prog_dsel` = 1 it goes to data memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Preload write enable |
| prog_dsel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| prog_addr | input | LOAD_AW | Preload word index |
| prog_wdata | input | XLEN | Preload data (low 32 bits used for instructions) |
| end_addr | input | XLEN | PC value that raises `halt_o` |
| pc_o | output | XLEN | Current program counter |
| rdata_o | output | XLEN | Data word read by the current load, else 0 |
| halt_o | output | 1 | High while `pc_o` equals `end_addr` |

## Verification
Only loads make data visible at the ports, so each ALU result has to be routed out by a store followed by a load. The random programs are therefore built as operand loads, an operation, a store and a read-back, with the expected word computed in the bench. The hardest state to reach is proof that something did not happen: that an unknown opcode or a write to register 31 left state untouched. Directed programs seed a known value, issue the suspect instruction, then store and reload the target register. Branch paths (taken, not taken, backward) are shown by the PC trace cycle by cycle.

// File: rtl/sc64_pkg.sv
package sc64_pkg;

   typedef enum logic [3:0] {
      ALU_AND   = 4'b0000,
      ALU_ORR   = 4'b0001,
      ALU_ADD   = 4'b0010,
      ALU_SUB   = 4'b0011,
      ALU_PASSB = 4'b0100
   } alu_op_e;

   typedef enum logic [1:0] {
      IMM_ARITH = 2'd0,
      IMM_MEM   = 2'd1,
      IMM_CBR   = 2'd2,
      IMM_JMP   = 2'd3
   } imm_fmt_e;

   typedef struct packed {
      logic     rsel_low;   // second read index from bits 4:0
      logic     use_imm;    // ALU operand B is the immediate
      logic     wb_mem;     // write back memory data
      logic     reg_we;
      logic     mem_rd;
      logic     mem_wr;
      logic     br_zero;    // conditional on ALU zero
      logic     br_always;
      alu_op_e  alu_op;
      imm_fmt_e fmt;
   } ctrl_t;

   localparam logic [10:0] OPC_ADD  = 11'b10001011000;
   localparam logic [10:0] OPC_SUB  = 11'b11001011000;
   localparam logic [10:0] OPC_AND  = 11'b10001010000;
   localparam logic [10:0] OPC_ORR  = 11'b10101010000;
   localparam logic [10:0] OPC_LOAD = 11'b11111000010;
   localparam logic [10:0] OPC_STOR = 11'b11111000000;
   localparam logic [9:0]  OPC_ADDI = 10'b1001000100;
   localparam logic [9:0]  OPC_SUBI = 10'b1101000100;
   localparam logic [5:0]  OPC_JMP  = 6'b000101;
   localparam logic [7:0]  OPC_CBZ  = 8'b10110100;

endpackage

// File: rtl/sc64_decode.sv
module sc64_decode
   import sc64_pkg::*;
(
   input  logic [10:0] opcode,
   output ctrl_t       ctrl
);

   always_comb begin
      ctrl = '0;
      if (opcode == OPC_ADD || opcode == OPC_SUB ||
          opcode == OPC_AND || opcode == OPC_ORR) begin
         ctrl.reg_we = 1'b1;
         ctrl.fmt    = IMM_ARITH;
         unique case (opcode)
            OPC_ADD: ctrl.alu_op = ALU_ADD;
            OPC_SUB: ctrl.alu_op = ALU_SUB;
            OPC_AND: ctrl.alu_op = ALU_AND;
            default: ctrl.alu_op = ALU_ORR;
         endcase
      end else if (opcode == OPC_LOAD) begin
         ctrl.mem_rd   = 1'b1;
         ctrl.wb_mem   = 1'b1;
         ctrl.reg_we   = 1'b1;
         ctrl.use_imm  = 1'b1;
         ctrl.rsel_low = 1'b1;
         ctrl.alu_op   = ALU_ADD;
         ctrl.fmt      = IMM_MEM;
      end else if (opcode == OPC_STOR) begin
         ctrl.mem_wr   = 1'b1;
         ctrl.use_imm  = 1'b1;
         ctrl.rsel_low = 1'b1;
         ctrl.alu_op   = ALU_ADD;
         ctrl.fmt      = IMM_MEM;
      end else if (opcode[10:1] == OPC_ADDI || opcode[10:1] == OPC_SUBI) begin
         ctrl.reg_we  = 1'b1;
         ctrl.use_imm = 1'b1;
         ctrl.fmt     = IMM_ARITH;
         ctrl.alu_op  = (opcode[10:1] == OPC_SUBI) ? ALU_SUB : ALU_ADD;
      end else if (opcode[10:5] == OPC_JMP) begin
         ctrl.br_always = 1'b1;
         ctrl.fmt       = IMM_JMP;
      end else if (opcode[10:3] == OPC_CBZ) begin
         ctrl.br_zero  = 1'b1;
         ctrl.rsel_low = 1'b1;
         ctrl.alu_op   = ALU_PASSB;
         ctrl.fmt      = IMM_CBR;
      end
   end

endmodule

// File: rtl/sc64_immgen.sv
module sc64_immgen
   import sc64_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [25:0]     field,
   input  imm_fmt_e        fmt,
   output logic [XLEN-1:0] imm
);

   localparam int W_ARITH = 12;
   localparam int W_MEM   = 9;
   localparam int W_CBR   = 19;
   localparam int W_JMP   = 26;

   always_comb begin
      unique case (fmt)
         IMM_ARITH: imm = {{(XLEN-W_ARITH){1'b0}}, field[21:10]};
         IMM_MEM:   imm = {{(XLEN-W_MEM){field[20]}}, field[20:12]};
         IMM_CBR:   imm = {{(XLEN-W_CBR){field[23]}}, field[23:5]};
         default:   imm = {{(XLEN-W_JMP){field[25]}}, field[25:0]};
      endcase
   end

endmodule

// File: rtl/sc64_regfile.sv
module sc64_regfile #(
   parameter int XLEN  = 64,
   parameter int NREGS = 32,
   parameter int RIW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [RIW-1:0]  ra1,
   input  logic [RIW-1:0]  ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   input  logic            we,
   input  logic [RIW-1:0]  wa,
   input  logic [XLEN-1:0] wd
);

   localparam int ZERO_IDX = NREGS - 1;

   logic [XLEN-1:0] entry [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_entry
      if (g == ZERO_IDX) begin : g_zero
         assign entry[g] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && wa == RIW'(g))
               q <= wd;
         end
         assign entry[g] = q;
      end
   end

   assign rd1 = entry[ra1];
   assign rd2 = entry[ra2];

endmodule

// File: rtl/sc64_alu.sv
module sc64_alu
   import sc64_pkg::*;
#(
   parameter int XLEN         = 64,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   logic [XLEN-1:0] sum;
   logic            is_sub;

   assign is_sub = (op == ALU_SUB);

   if (SHARED_ADDER) begin : g_shared
      logic [XLEN-1:0] b_eff;
      assign b_eff = is_sub ? ~b : b;
      assign sum   = a + b_eff + {{(XLEN-1){1'b0}}, is_sub};
   end else begin : g_split
      assign sum = is_sub ? (a - b) : (a + b);
   end

   always_comb begin
      unique case (op)
         ALU_AND:         y = a & b;
         ALU_ORR:         y = a | b;
         ALU_ADD,
         ALU_SUB:         y = sum;
         ALU_PASSB:       y = b;
         default:         y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc64_nextpc.sv
module sc64_nextpc #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] imm,
   input  logic            br_always,
   input  logic            br_zero,
   input  logic            alu_zero,
   output logic            taken,
   output logic [XLEN-1:0] pc_nxt
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] target;

   assign target = pc + {imm[XLEN-3:0], 2'b00};
   assign taken  = br_always | (br_zero & alu_zero);
   assign pc_nxt = taken ? target : (pc + STEP);

endmodule

// File: rtl/sc64_wordmem.sv
module sc64_wordmem #(
   parameter int W     = 64,
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/sc64_core.sv
module sc64_core
   import sc64_pkg::*;
#(
   parameter int XLEN         = 64,
   parameter int ILEN         = 32,
   parameter int NREGS        = 32,
   parameter int IMEM_WORDS   = 64,
   parameter int DMEM_WORDS   = 64,
   parameter int LOAD_AW      = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               prog_we,
   input  logic               prog_dsel,
   input  logic [LOAD_AW-1:0] prog_addr,
   input  logic [XLEN-1:0]    prog_wdata,
   input  logic [XLEN-1:0]    end_addr,
   output logic [XLEN-1:0]    pc_o,
   output logic [XLEN-1:0]    rdata_o,
   output logic               halt_o
);

   localparam int IAW = $clog2(IMEM_WORDS);
   localparam int DAW = $clog2(DMEM_WORDS);
   localparam int RIW = $clog2(NREGS);

   if (ILEN != 32) begin : g_bad_ilen
      $error("sc64_core: ILEN must be 32");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("sc64_core: five-bit register fields need NREGS = 32");
   end
   if (XLEN < 32) begin : g_bad_xlen
      $error("sc64_core: XLEN must hold a 26-bit offset shifted by 2");
   end
   if ((1 << IAW) != IMEM_WORDS || (1 << DAW) != DMEM_WORDS) begin : g_bad_depth
      $error("sc64_core: memory depths must be powers of two");
   end
   if (LOAD_AW < IAW || LOAD_AW < DAW) begin : g_bad_load_aw
      $error("sc64_core: LOAD_AW too narrow for the memories");
   end

   // ---------------- state and fetch
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_nxt;
   logic [ILEN-1:0] instr;

   sc64_wordmem #(
      .W     (ILEN),
      .DEPTH (IMEM_WORDS)
   ) u_imem (
      .clk   (clk),
      .we    (prog_we & ~prog_dsel),
      .waddr (prog_addr[IAW-1:0]),
      .wdata (prog_wdata[ILEN-1:0]),
      .raddr (pc_q[IAW+1:2]),
      .rdata (instr)
   );

   // ---------------- decode
   ctrl_t ctrl;

   sc64_decode u_dec (
      .opcode (instr[31:21]),
      .ctrl   (ctrl)
   );

   // ---------------- operands
   logic [RIW-1:0]  ra1, ra2, wa;
   logic [XLEN-1:0] rd1, rd2, wb_data;
   logic            rf_we;

   assign ra1   = instr[9:5];
   assign ra2   = ctrl.rsel_low ? instr[4:0] : instr[20:16];
   assign wa    = instr[4:0];
   assign rf_we = ctrl.reg_we & ~rst;

   sc64_regfile #(
      .XLEN  (XLEN),
      .NREGS (NREGS)
   ) u_rf (
      .clk (clk),
      .rst (rst),
      .ra1 (ra1),
      .ra2 (ra2),
      .rd1 (rd1),
      .rd2 (rd2),
      .we  (rf_we),
      .wa  (wa),
      .wd  (wb_data)
   );

   logic [XLEN-1:0] imm;

   sc64_immgen #(
      .XLEN (XLEN)
   ) u_imm (
      .field (instr[25:0]),
      .fmt   (ctrl.fmt),
      .imm   (imm)
   );

   // ---------------- execute
   logic [XLEN-1:0] opb, alu_y;
   logic            alu_zero;

   assign opb = ctrl.use_imm ? imm : rd2;

   sc64_alu #(
      .XLEN         (XLEN),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .op   (ctrl.alu_op),
      .a    (rd1),
      .b    (opb),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // ---------------- data memory
   logic            dm_we, core_wr;
   logic [DAW-1:0]  dm_waddr;
   logic [XLEN-1:0] dm_wdata, dm_rdata;
   logic            prog_dm;

   assign prog_dm  = prog_we & prog_dsel;
   assign core_wr  = ctrl.mem_wr & ~rst;
   assign dm_we    = prog_dm | core_wr;
   assign dm_waddr = prog_dm ? prog_addr[DAW-1:0] : alu_y[DAW+2:3];
   assign dm_wdata = prog_dm ? prog_wdata : rd2;

   sc64_wordmem #(
      .W     (XLEN),
      .DEPTH (DMEM_WORDS)
   ) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (alu_y[DAW+2:3]),
      .rdata (dm_rdata)
   );

   assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

   // ---------------- next PC
   logic taken;

   sc64_nextpc #(
      .XLEN (XLEN)
   ) u_npc (
      .pc        (pc_q),
      .imm       (imm),
      .br_always (ctrl.br_always),
      .br_zero   (ctrl.br_zero),
      .alu_zero  (alu_zero),
      .taken     (taken),
      .pc_nxt    (pc_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_nxt;
   end

   // ---------------- debug outputs
   assign pc_o    = pc_q;
   assign rdata_o = ctrl.mem_rd ? dm_rdata : '0;
   assign halt_o  = (pc_q == end_addr);

   logic unused_preload_bits;
   assign unused_preload_bits = ^{prog_addr, prog_wdata};

endmodule

// File: rtl/sc64_core_chk.sv
module sc64_core_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] pc_o,
   input logic [XLEN-1:0] imm,
   input logic            taken,
   input logic            br_zero,
   input logic            alu_zero,
   input logic [XLEN-1:0] rd2,
   input logic [4:0]      ra2,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic            reg_we,
   input logic [XLEN-1:0] rdata_o
);

   AST_PC_CLEARED: assert property (@(posedge clk) rst |=> (pc_o == '0)); // R1

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      !taken |=> (pc_o == $past(pc_o) + XLEN'(4))); // R8

   AST_PC_TARGET: assert property (@(posedge clk) disable iff (rst)
      taken |=> (pc_o == $past(pc_o) + {$past(imm[XLEN-3:0]), 2'b00})); // R7

   AST_CBZ_TESTS_REG: assert property (@(posedge clk) disable iff (rst)
      br_zero |-> (alu_zero == (rd2 == '0))); // R6

   AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
      (ra2 == 5'd31) |-> (rd2 == '0)); // R5

   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (!reg_we && !mem_rd)); // R4

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
      !mem_rd |-> (rdata_o == '0)); // R10

endmodule

bind sc64_core sc64_core_chk #(
   .XLEN (XLEN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc_o     (pc_o),
   .imm      (imm),
   .taken    (taken),
   .br_zero  (ctrl.br_zero),
   .alu_zero (alu_zero),
   .rd2      (rd2),
   .ra2      (ra2),
   .mem_rd   (ctrl.mem_rd),
   .mem_wr   (ctrl.mem_wr),
   .reg_we   (ctrl.reg_we),
   .rdata_o  (rdata_o)
);

// File: tb/tb_sc64_core.sv
module tb_sc64_core;

   localparam int XLEN  = 64;
   localparam int WORDS = 64;
   localparam int NTR   = 64;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            prog_we = 1'b0;
   logic            prog_dsel = 1'b0;
   logic [7:0]      prog_addr = '0;
   logic [63:0]     prog_wdata = '0;
   logic [63:0]     end_addr = '1;
   logic [63:0]     pc_o, rdata_o;
   logic            halt_o;

   always #5 clk = ~clk;

   sc64_core dut (
      .clk        (clk),
      .rst        (rst),
      .prog_we    (prog_we),
      .prog_dsel  (prog_dsel),
      .prog_addr  (prog_addr),
      .prog_wdata (prog_wdata),
      .end_addr   (end_addr),
      .pc_o       (pc_o),
      .rdata_o    (rdata_o),
      .halt_o     (halt_o)
   );

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [31:0] prog  [WORDS];
   logic [63:0] dinit [WORDS];
   logic [63:0] tr_pc [NTR];
   logic [63:0] tr_rd [NTR];
   logic        tr_h  [NTR];

   // encodings from the requirements
   localparam logic [10:0] E_ADD = 11'b10001011000, E_SUB = 11'b11001011000;
   localparam logic [10:0] E_AND = 11'b10001010000, E_ORR = 11'b10101010000;
   localparam logic [10:0] E_LD  = 11'b11111000010, E_ST  = 11'b11111000000;
   localparam logic [9:0]  E_ADDI = 10'b1001000100, E_SUBI = 10'b1101000100;
   localparam logic [31:0] E_BAD = 32'hFFE0_0002;   // unknown opcode, dest field 2

   function automatic logic [31:0] enc_r(logic [10:0] op, int rm, int rn, int rd);
      return {op, 5'(rm), 6'b0, 5'(rn), 5'(rd)};
   endfunction
   function automatic logic [31:0] enc_i(logic [9:0] op, logic [11:0] k, int rn, int rd);
      return {op, k, 5'(rn), 5'(rd)};
   endfunction
   function automatic logic [31:0] enc_d(logic [10:0] op, logic [8:0] ofs, int rn, int rt);
      return {op, ofs, 2'b00, 5'(rn), 5'(rt)};
   endfunction
   function automatic logic [31:0] enc_b(logic [25:0] ofs);
      return {6'b000101, ofs};
   endfunction
   function automatic logic [31:0] enc_cbz(logic [18:0] ofs, int rt);
      return {8'b10110100, ofs, 5'(rt)};
   endfunction

   function automatic logic [63:0] ref_op(int sel, logic [63:0] a, logic [63:0] b);
      case (sel)
         0:       return a + b;
         1:       return a - b;
         2:       return a & b;
         default: return a | b;
      endcase
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_buffers();
      for (int i = 0; i < WORDS; i++) begin
         prog[i]  = '0;
         dinit[i] = '0;
      end
   endtask

   // preload both memories under reset, then trace ncyc cycles
   task automatic run(int ncyc, bit stop_on_halt);
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < WORDS; i++) begin
         prog_we = 1'b1; prog_dsel = 1'b0; prog_addr = 8'(i); prog_wdata = {32'h0, prog[i]};
         @(negedge clk);
      end
      for (int i = 0; i < WORDS; i++) begin
         prog_we = 1'b1; prog_dsel = 1'b1; prog_addr = 8'(i); prog_wdata = dinit[i];
         @(negedge clk);
      end
      prog_we = 1'b0;
      @(negedge clk);
      check("R1 pc under reset", pc_o, 64'h0);
      rst = 1'b0;
      for (int c = 0; c < ncyc && c < NTR; c++) begin
         #1;
         tr_pc[c] = pc_o;
         tr_rd[c] = rdata_o;
         tr_h[c]  = halt_o;
         if (stop_on_halt && halt_o) break;
         @(negedge clk);
      end
   endtask

   task automatic test_random();
      void'($urandom(32'h5C64_0001));
      for (int it = 0; it < 40; it++) begin
         logic [63:0] a, b;
         logic [11:0] k;
         int sel;
         bit subi;
         a    = {$urandom, $urandom};
         b    = {$urandom, $urandom};
         k    = 12'($urandom);
         sel  = it % 4;
         subi = it[2];
         if (it == 0) begin a = '1; b = 64'h1; end          // carry out of bit 63
         if (it == 1) begin b = a; end                       // equal operands
         if (it == 2) begin a = 64'h0; k = 12'hFFF; end      // largest immediate
         if (it == 5) begin a = 64'h5; k = 12'hFFF; end      // immediate wraps below zero
         clear_buffers();
         dinit[0] = a;
         dinit[1] = b;
         dinit[2] = 64'hA5A5;
         dinit[3] = 64'h5A5A;
         prog[0] = enc_d(E_LD, 9'h000, 31, 1);
         prog[1] = enc_d(E_LD, 9'h008, 31, 2);
         case (sel)
            0:       prog[2] = enc_r(E_ADD, 2, 1, 3);
            1:       prog[2] = enc_r(E_SUB, 2, 1, 3);
            2:       prog[2] = enc_r(E_AND, 2, 1, 3);
            default: prog[2] = enc_r(E_ORR, 2, 1, 3);
         endcase
         prog[3] = enc_d(E_ST, 9'h010, 31, 3);
         prog[4] = enc_d(E_LD, 9'h010, 31, 4);
         prog[5] = enc_i(subi ? E_SUBI : E_ADDI, k, 1, 5);
         prog[6] = enc_d(E_ST, 9'h018, 31, 5);
         prog[7] = enc_d(E_LD, 9'h018, 31, 6);
         run(8, 1'b0);
         check("R4 load data", tr_rd[0], a);
         check("R2 register op", tr_rd[4], ref_op(sel, a, b));
         check("R3 immediate op", tr_rd[7],
               subi ? a - {52'h0, k} : a + {52'h0, k});
      end
   endtask

   task automatic test_reset_clears();
      clear_buffers();
      dinit[0] = 64'h99;
      prog[0]  = enc_d(E_ST, 9'h000, 31, 3);
      prog[1]  = enc_d(E_LD, 9'h000, 31, 4);
      run(2, 1'b0);
      check("R1 register cleared by reset", tr_rd[1], 64'h0);
   endtask

   task automatic test_offsets();
      clear_buffers();
      dinit[8]  = 64'h40;
      dinit[7]  = 64'h777;
      dinit[31] = 64'h31F;
      prog[0] = enc_d(E_LD, 9'h040, 31, 1);
      prog[1] = enc_d(E_LD, 9'h1F8, 1, 2);   // -8 from 0x40
      prog[2] = enc_d(E_LD, 9'h0F8, 31, 3);  // largest positive offset
      prog[3] = enc_r(E_ADD, 2, 3, 7);       // ensures no stray bits
      run(4, 1'b0);
      check("R4 negative offset", tr_rd[1], 64'h777);
      check("R4 largest positive offset", tr_rd[2], 64'h31F);
   endtask

   task automatic test_zero_reg();
      clear_buffers();
      dinit[0] = 64'h5;
      dinit[1] = 64'hDEAD;
      prog[0] = enc_d(E_LD, 9'h000, 31, 31);  // write to index 31 dropped
      prog[1] = enc_r(E_ADD, 31, 31, 3);
      prog[2] = enc_d(E_ST, 9'h008, 31, 3);
      prog[3] = enc_d(E_LD, 9'h008, 31, 4);
      prog[4] = enc_d(E_ST, 9'h000, 31, 31);
      prog[5] = enc_d(E_LD, 9'h000, 31, 5);
      run(6, 1'b0);
      check("R5 index 31 reads zero after write", tr_rd[3], 64'h0);
      check("R5 storing index 31 stores zero", tr_rd[5], 64'h0);
   endtask

   task automatic test_branches();
      clear_buffers();
      dinit[0] = 64'h7;
      dinit[1] = 64'h55;
      prog[0]  = enc_d(E_LD, 9'h000, 31, 1);
      prog[1]  = enc_cbz(19'd5, 1);           // not taken
      prog[2]  = enc_cbz(19'd2, 31);          // taken to 0x10
      prog[4]  = enc_b(26'd4);                // to 0x20
      prog[5]  = enc_i(E_ADDI, 12'hFFF, 31, 2);
      prog[6]  = E_BAD;
      prog[7]  = enc_b(26'd3);                // to 0x28
      prog[8]  = enc_b(26'h3FFFFFD);          // back to 0x14
      prog[10] = enc_d(E_ST, 9'h008, 31, 2);
      prog[11] = enc_d(E_LD, 9'h008, 31, 3);
      end_addr = 64'h2C;
      run(10, 1'b0);
      check("R8 sequential fetch", tr_pc[1], 64'h4);
      check("R6 zero-test not taken", tr_pc[2], 64'h8);
      check("R6 zero-test taken", tr_pc[3], 64'h10);
      check("R7 forward jump", tr_pc[4], 64'h20);
      check("R7 backward jump", tr_pc[5], 64'h14);
      check("R9 unknown opcode advances", tr_pc[7], 64'h1C);
      check("R9 unknown opcode writes nothing", tr_rd[9], 64'hFFF);
      check("R10 idle read data", tr_rd[4], 64'h0);
      check("R11 halt low", {63'h0, tr_h[8]}, 64'h0);
      check("R11 halt high", {63'h0, tr_h[9]}, 64'h1);
      end_addr = '1;
   endtask

   task automatic test_countdown();
      clear_buffers();
      dinit[0] = 64'h1;
      dinit[1] = 64'hA;
      dinit[2] = 64'h5;
      dinit[3] = 64'h1234_5678_9ABC_EDFA;
      dinit[4] = 64'h0;
      prog[0]  = enc_d(E_LD, 9'h000, 31, 9);
      prog[1]  = enc_d(E_LD, 9'h008, 31, 10);
      prog[2]  = enc_d(E_LD, 9'h010, 31, 11);
      prog[3]  = enc_d(E_LD, 9'h018, 31, 12);
      prog[4]  = enc_d(E_LD, 9'h020, 31, 13);
      prog[5]  = enc_r(E_ORR, 11, 10, 10);
      prog[6]  = enc_r(E_AND, 10, 12, 12);
      prog[7]  = enc_cbz(19'd4, 12);
      prog[8]  = enc_r(E_ADD, 9, 13, 13);
      prog[9]  = enc_r(E_SUB, 9, 12, 12);
      prog[10] = enc_b(26'h3FFFFFD);
      prog[11] = enc_d(E_ST, 9'h020, 31, 13);
      prog[12] = enc_d(E_LD, 9'h020, 31, 13);
      end_addr = 64'h30;
      run(NTR, 1'b1);
      check("R12 program reaches end", {63'h0, halt_o}, 64'h1);
      check("R12 counted value at 0x20", rdata_o, 64'hA);
      end_addr = '1;
   endtask

   task automatic test_preload();
      clear_buffers();
      for (int i = 0; i < 16; i++) begin
         dinit[i] = 64'h1000 * 64'(i) + 64'h3;
         prog[i]  = enc_d(E_LD, 9'(i * 8), 31, 1);
      end
      run(16, 1'b0);
      check("R13 preload first word", tr_rd[0], 64'h3);
      check("R13 preload last word", tr_rd[15], 64'hF003);
   endtask

   initial begin
      fork
         begin
            test_reset_clears();
            test_random();
            test_reset_clears();
            test_offsets();
            test_zero_reg();
            test_branches();
            test_countdown();
            test_preload();
            done = 1'b1;
         end
         begin
            repeat (150000) @(posedge clk);
         end
      join_any
      if (!done) begin
         nvec++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule